// File: doc/BRIEF.md
# Single-Bit Memory Read-Modify-Write Engine

This engine performs one bit operation on a byte held in memory: force the bit to 1, flip it, force it to 0, or only examine it. The caller supplies a 32-bit base value, a signed 16-bit offset and a 3-bit bit index. The engine adds the offset, sign-extended, to the base to form a byte address. It then fetches that byte over a byte-wide memory port with a ready handshake and computes the zero flag from the bit's value as fetched. Except for the examine-only operation, it writes the altered byte back to the same address.

A request is taken only while the engine is idle. Completion is marked by a single-cycle done pulse. The zero flag takes its new value in that same cycle and keeps it until the next completion. The examine-only operation leaves out the write phase completely, so memory sees one read and nothing else.

Top module: `bit_rmw_unit`

## Requirements
- R1: While reset is asserted and after it is released, `busy_o`, `mem_rd_o`, `mem_wr_o`, `done_o` and `z_o` are all 0.
- R2: The memory address is `base_i` plus `disp_i` sign-extended to 32 bits, wrapping modulo 2^32. It is held stable while a transfer waits for `mem_ready_i`.
- R3: Each operation performs exactly one byte read. `mem_rd_o` stays high until a cycle in which `mem_ready_i` is high, and `mem_rdata_i` is taken in that cycle.
- R4: On completion, `z_o` is 1 if bit `bit_sel_i` (0 = LSB) of the byte as read was 0, and 0 otherwise.
- R5: With `op_i` = 2'b00 (set), the written byte is the read byte with the selected bit forced to 1.
- R6: With `op_i` = 2'b01 (invert), the written byte is the read byte with the selected bit flipped.
- R7: With `op_i` = 2'b10 (clear), the written byte is the read byte with the selected bit forced to 0.
- R8: With `op_i` = 2'b11 (test), no write is issued and the memory byte is unchanged.
- R9: For set, invert and clear, exactly one write goes to the address that was read. `mem_wr_o` and `mem_wdata_o` are held until `mem_ready_i`.
- R10: `req_i` and the command inputs are ignored while `busy_o` is high. After completion the engine returns to idle.
- R11: `done_o` is a one-cycle pulse. `z_o` changes only in the done cycle and holds its value between operations.
- R12: `mem_rd_o` and `mem_wr_o` are never high together, and a write is issued only after the read has completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Start request, taken only while idle |
| op_i | input | 2 | 00 set, 01 invert, 10 clear, 11 test |
| base_i | input | 32 | Base address value |
| disp_i | input | 16 | Signed byte offset |
| bit_sel_i | input | 3 | Bit index inside the byte, 0 = LSB |
| busy_o | output | 1 | Operation in progress |
| mem_addr_o | output | 32 | Byte address |
| mem_rd_o | output | 1 | Read request, held until ready |
| mem_wr_o | output | 1 | Write request, held until ready |
| mem_wdata_o | output | 8 | Byte to write |
| mem_rdata_i | input | 8 | Read byte, valid with ready |
| mem_ready_i | input | 1 | Memory completes the pending transfer |
| done_o | output | 1 | One-cycle completion pulse |
| z_o | output | 1 | Zero flag from the original bit |

## Verification
Each operation is applied both to a bit that is already 1 and to one that is 0. This separates idempotent set and clear from a true flip, and it shows that Z follows the pre-modification value rather than the written one. Test operations follow writes to the same byte, which shows that the earlier write landed and that the test changes nothing. Offsets that are negative, at the most negative value, or large enough to wrap the base exercise the sign extension. Memory latency runs from zero wait cycles to several, and the bench raises new requests with different fields in mid-operation; together these expose any early capture of read data, any dropped request hold, and any acceptance of a request while busy.

// File: rtl/bit_rmw_pkg.sv
package bit_rmw_pkg;
  typedef enum logic [1:0] {
    OP_SET = 2'b00,
    OP_INV = 2'b01,
    OP_CLR = 2'b10,
    OP_TST = 2'b11
  } rmw_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WAIT_RD,
    ST_MODIFY,
    ST_WRITE,
    ST_WAIT_WR,
    ST_DONE
  } rmw_state_e;
endpackage

// File: rtl/bit_rmw_agen.sv
module bit_rmw_agen #(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 16
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [DISP_W-1:0] disp_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] disp_ext;

  generate
    if (DISP_W < ADDR_W) begin : g_sext
      assign disp_ext = {{(ADDR_W-DISP_W){disp_i[DISP_W-1]}}, disp_i};
    end else begin : g_trunc
      assign disp_ext = disp_i[ADDR_W-1:0];
    end
  endgenerate

  assign addr_o = base_i + disp_ext;
endmodule

// File: rtl/bit_rmw_alu.sv
module bit_rmw_alu
  import bit_rmw_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int BIT_W  = 3
) (
  input  rmw_op_e           op_i,
  input  logic [BIT_W-1:0]  bit_sel_i,
  input  logic [DATA_W-1:0] din_i,
  output logic [DATA_W-1:0] dout_o,
  output logic              zero_o
);
  logic [DATA_W-1:0] mask;

  for (genvar i = 0; i < DATA_W; i++) begin : g_lane
    assign mask[i]   = (bit_sel_i == BIT_W'(i));
    assign dout_o[i] = (op_i == OP_SET) ? (din_i[i] | mask[i])  :
                       (op_i == OP_INV) ? (din_i[i] ^ mask[i])  :
                       (op_i == OP_CLR) ? (din_i[i] & ~mask[i]) :
                                          din_i[i];
  end

  // zero flag taken from the unmodified byte
  assign zero_o = ~|(din_i & mask);
endmodule

// File: rtl/bit_rmw_fsm.sv
module bit_rmw_fsm
  import bit_rmw_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic test_i,
  input  logic ready_i,
  output logic accept_o,
  output logic rd_o,
  output logic wr_o,
  output logic rd_fire_o,
  output logic enter_done_o,
  output logic done_o,
  output logic busy_o
);
  rmw_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (req_i) state_d = ST_READ;
      ST_READ:    state_d = ready_i ? ST_MODIFY : ST_WAIT_RD;
      ST_WAIT_RD: if (ready_i) state_d = ST_MODIFY;
      ST_MODIFY:  state_d = test_i ? ST_DONE : ST_WRITE;
      ST_WRITE:   state_d = ready_i ? ST_DONE : ST_WAIT_WR;
      ST_WAIT_WR: if (ready_i) state_d = ST_DONE;
      ST_DONE:    state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign accept_o     = (state_q == ST_IDLE) && req_i;
  assign rd_o         = (state_q == ST_READ) || (state_q == ST_WAIT_RD);
  assign wr_o         = (state_q == ST_WRITE) || (state_q == ST_WAIT_WR);
  assign rd_fire_o    = rd_o && ready_i;
  assign enter_done_o = (state_d == ST_DONE) && (state_q != ST_DONE);
  assign done_o       = (state_q == ST_DONE);
  assign busy_o       = (state_q != ST_IDLE);

  AST_RW_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_o && wr_o)) else $error("rd and wr together"); // R12
  AST_RD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_o && !ready_i |=> rd_o) else $error("read dropped"); // R3
  AST_WR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o && !ready_i |=> wr_o) else $error("write dropped"); // R9
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o) else $error("done longer than one cycle"); // R11
  AST_IDLE_AFTER_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o) else $error("not idle after done"); // R10
endmodule

// File: rtl/bit_rmw_unit.sv
module bit_rmw_unit
  import bit_rmw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       req_i,
  input  logic [1:0]                 op_i,
  input  logic [ADDR_W-1:0]          base_i,
  input  logic [DISP_W-1:0]          disp_i,
  input  logic [$clog2(DATA_W)-1:0]  bit_sel_i,
  output logic                       busy_o,
  output logic [ADDR_W-1:0]          mem_addr_o,
  output logic                       mem_rd_o,
  output logic                       mem_wr_o,
  output logic [DATA_W-1:0]          mem_wdata_o,
  input  logic [DATA_W-1:0]          mem_rdata_i,
  input  logic                       mem_ready_i,
  output logic                       done_o,
  output logic                       z_o
);
  localparam int BIT_W = $clog2(DATA_W);

  logic [ADDR_W-1:0] ea;
  logic [ADDR_W-1:0] addr_q;
  rmw_op_e           op_q;
  logic [BIT_W-1:0]  bit_q;
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] new_byte;
  logic              zero;
  logic              z_q;
  logic              accept, rd_fire, enter_done;

  bit_rmw_agen #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_agen (
    .base_i (base_i),
    .disp_i (disp_i),
    .addr_o (ea)
  );

  bit_rmw_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_i        (req_i),
    .test_i       (op_q == OP_TST),
    .ready_i      (mem_ready_i),
    .accept_o     (accept),
    .rd_o         (mem_rd_o),
    .wr_o         (mem_wr_o),
    .rd_fire_o    (rd_fire),
    .enter_done_o (enter_done),
    .done_o       (done_o),
    .busy_o       (busy_o)
  );

  bit_rmw_alu #(.DATA_W(DATA_W), .BIT_W(BIT_W)) u_alu (
    .op_i      (op_q),
    .bit_sel_i (bit_q),
    .din_i     (rdata_q),
    .dout_o    (new_byte),
    .zero_o    (zero)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      op_q   <= OP_TST;
      bit_q  <= '0;
    end else if (accept) begin
      addr_q <= ea;
      op_q   <= rmw_op_e'(op_i);
      bit_q  <= bit_sel_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (rd_fire) rdata_q <= mem_rdata_i;
  end

  // flag published together with done
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         z_q <= 1'b0;
    else if (enter_done) z_q <= zero;
  end

  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = new_byte;
  assign z_o         = z_q;

  AST_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_o || mem_wr_o) && !mem_ready_i |=> $stable(mem_addr_o))
    else $error("address moved during transfer"); // R2
  AST_WDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o && !mem_ready_i |=> $stable(mem_wdata_o))
    else $error("write data moved"); // R9
  AST_TEST_NO_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && (op_q == OP_TST) |-> !mem_wr_o)
    else $error("write issued for test"); // R8
  AST_Z_AT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(z_o) |-> done_o)
    else $error("z changed outside done"); // R11
endmodule

// File: tb/bit_rmw_unit_tb.sv
`timescale 1ns/1ps
module bit_rmw_unit_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic [1:0]  op_i = 2'b00;
  logic [31:0] base_i = '0;
  logic [15:0] disp_i = '0;
  logic [2:0]  bit_sel_i = '0;
  logic        busy_o;
  logic [31:0] mem_addr_o;
  logic        mem_rd_o, mem_wr_o;
  logic [7:0]  mem_wdata_o;
  logic [7:0]  mem_rdata_i = 8'hA5;
  logic        mem_ready_i = 1'b0;
  logic        done_o, z_o;

  bit_rmw_unit u_dut (.*);

  always #5 clk_i = ~clk_i;

  int tests = 0, fails = 0, cyc = 0;
  logic [7:0] mem [int unsigned];
  int wait_cnt = 0, lat = 0, lat_mode = 0;
  logic [15:0] lfsr = 16'hACE1;
  bit wr_pend = 0;
  logic [31:0] wr_pend_a;
  logic [7:0]  wr_pend_d;
  int rd_cnt, wr_cnt;
  logic [31:0] seen_rd_a, seen_wr_a;
  logic [7:0]  seen_wd;

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      fails++; tests++;
      $display("FAIL watchdog: act=%0d exp<=150000 cycles", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  function automatic logic [7:0] rd_byte(logic [31:0] a);
    return mem.exists(a) ? mem[a] : (a[7:0] ^ 8'h5A);
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  function automatic int next_lat();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return (lat_mode == 0) ? 0 : int'(lfsr[2:0] % 5);
  endfunction

  // one cycle of the behavioural memory, evaluated at the falling edge
  task automatic tick();
    @(negedge clk_i);
    if (wr_pend) begin
      mem[wr_pend_a] = wr_pend_d;
      wr_pend = 0;
    end
    if (mem_rd_o && mem_wr_o) chk(0, "R12", 32'd1, 32'd0);
    if (mem_wr_o && rd_cnt == 0) chk(0, "R12", 32'd0, 32'd1);
    mem_ready_i = 1'b0;
    mem_rdata_i = 8'hA5;
    if (mem_rd_o || mem_wr_o) begin
      if (wait_cnt >= lat) begin
        mem_ready_i = 1'b1;
        if (mem_rd_o) begin
          mem_rdata_i = rd_byte(mem_addr_o);
          rd_cnt++;
          seen_rd_a = mem_addr_o;
        end else begin
          wr_pend = 1; wr_pend_a = mem_addr_o; wr_pend_d = mem_wdata_o;
          wr_cnt++;
          seen_wr_a = mem_addr_o;
          seen_wd = mem_wdata_o;
        end
        wait_cnt = 0;
        lat = next_lat();
      end else wait_cnt++;
    end
  endtask

  task automatic run_op(logic [1:0] op, logic [31:0] base, logic [15:0] disp,
                        logic [2:0] bsel, bit noisy);
    logic [31:0] ea;
    logic [7:0]  orig, expn;
    logic        exp_z, z_before;
    int n;
    ea = base + {{16{disp[15]}}, disp};
    orig = rd_byte(ea);
    exp_z = ~orig[bsel];
    case (op)
      2'b00: expn = orig | (8'd1 << bsel);
      2'b01: expn = orig ^ (8'd1 << bsel);
      2'b10: expn = orig & ~(8'd1 << bsel);
      default: expn = orig;
    endcase
    rd_cnt = 0; wr_cnt = 0;
    z_before = z_o;
    req_i = 1; op_i = op; base_i = base; disp_i = disp; bit_sel_i = bsel;
    tick();
    if (noisy) begin
      // R10: a second request with other fields while busy
      op_i = ~op; base_i = ~base; disp_i = disp + 16'd3; bit_sel_i = ~bsel;
      tick();
    end
    req_i = 0;
    n = 0;
    while (!done_o && n < 200) begin
      if (z_o !== z_before) chk(0, "R11", {31'd0, z_o}, {31'd0, z_before});
      tick();
      n++;
    end
    chk(n < 200, "R10", n, 200);
    chk(rd_cnt == 1, "R3", rd_cnt, 1);
    chk(seen_rd_a == ea, "R2", seen_rd_a, ea);
    chk(z_o == exp_z, "R4", {31'd0, z_o}, {31'd0, exp_z});
    if (op == 2'b11) begin
      chk(wr_cnt == 0, "R8", wr_cnt, 0);
      chk(rd_byte(ea) == orig, "R8", rd_byte(ea), orig);
    end else begin
      chk(wr_cnt == 1 && seen_wr_a == ea, "R9", seen_wr_a, ea);
      chk(seen_wd == expn, op == 2'b00 ? "R5" : op == 2'b01 ? "R6" : "R7",
          seen_wd, expn);
      chk(rd_byte(ea) == expn, "R9", rd_byte(ea), expn);
    end
    tick();
    chk(done_o == 0, "R11", done_o, 0);
    chk(z_o == exp_z, "R11", z_o, exp_z);
    chk(!busy_o && rd_cnt == 1, "R10", {busy_o, 31'(rd_cnt)}, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk(!busy_o && !mem_rd_o && !mem_wr_o && !done_o && !z_o, "R1",
        {busy_o, mem_rd_o, mem_wr_o, done_o, z_o}, 0);
    rst_ni = 1;
    tick();
    chk(!busy_o && !mem_rd_o && !mem_wr_o && !done_o && !z_o, "R1",
        {busy_o, mem_rd_o, mem_wr_o, done_o, z_o}, 0);

    mem[32'h1010] = 8'h00;
    run_op(2'b00, 32'h1000, 16'h0010, 3'd3, 0); // R5 set 0 bit, Z=1
    run_op(2'b11, 32'h1000, 16'h0010, 3'd3, 0); // R8 test now 1, Z=0
    run_op(2'b00, 32'h1000, 16'h0010, 3'd3, 0); // R5 set already-1
    run_op(2'b10, 32'h1000, 16'h0010, 3'd3, 0); // R7 clear
    run_op(2'b10, 32'h1000, 16'h0010, 3'd3, 0); // R7 clear already-0
    run_op(2'b11, 32'h1000, 16'h0010, 3'd3, 0); // R4 Z=1
    run_op(2'b01, 32'h2000, 16'hFFF0, 3'd7, 0); // R6 negative offset
    run_op(2'b01, 32'h2000, 16'hFFF0, 3'd7, 1); // R6 flip back, R10 noise
    run_op(2'b00, 32'hFFFF_FFF8, 16'h0010, 3'd0, 0); // R2 wrap
    run_op(2'b10, 32'h0001_0000, 16'h8000, 3'd0, 1); // R2 most negative
    lat_mode = 1;
    lat = next_lat();
    run_op(2'b11, 32'h2000, 16'hFFF0, 3'd7, 1);
    for (int k = 0; k < 24; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      run_op(lfsr[1:0], 32'h3000 + {28'd0, lfsr[7:4]}, {12'd0, lfsr[11:8]},
             lfsr[14:12], k[0]);
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule